// File: doc/BRIEF.md
# Four-Pair Power Sourcing Supervisor

This block is the top-level sequencer of a power sourcing port that can feed a powered device over all four wire pairs. It first asks the measurement side for a connection check and a device-alternative check. It then decides how the two pairsets are handed to the pairset controllers that sit below it. A device with one shared signature that accepts power on both alternatives gets one controller driving both alternatives at once. A device with a separate signature on each alternative gets two independent controllers, one per alternative, and only the alternatives it reported are enabled.

Once it has handed off control, the supervisor watches the detection-fail flags from the controllers. It takes control back and repeats the checks only when every controller in use reports a failed detection. An alternative that was never configured counts as failed. In the shared-controller case the flag of the unused second controller is ignored. Dropping the enable input stops everything within one clock. The measurement functions and the pairset controllers are outside this block.

States: DISABLED, CONN_CHECK, SETUP_SINGLE, SETUP_DUAL, RUN_SINGLE, RUN_DUAL. Transitions:
- DISABLED to CONN_CHECK when enable is high.
- CONN_CHECK to SETUP_SINGLE, SETUP_DUAL or DISABLED when the check reports done.
- SETUP_SINGLE to RUN_SINGLE, and SETUP_DUAL to RUN_DUAL, unconditionally.
- RUN_SINGLE to CONN_CHECK and RUN_DUAL to CONN_CHECK on release.
- Any state to DISABLED when enable is low.

Top module: `quad_pair_supervisor`

## Requirements
- R1: After any clock edge at which `enable_i` is low (or reset is active), all outputs are 0. Stored check results are forced to invalid (signature 1, alternative 3).
- R2: From DISABLED with `enable_i` high, `chk_req_o` is 1 after the next edge and stays 1 until an edge at which `chk_done_i` is 1. Signature and alternative inputs are not used while `chk_done_i` is 0.
- R3: Done with signature code 2 (single) and alternative code 2 (both) gives a one-cycle setup. In that cycle `tcc_start_o`=1, `ps0_en_o`=1, `ps0_alt_o`=3 (BOTH) and `ps0_fail_clr_o`=1, with controller 1 off. The next cycle keeps `ps0_en_o`=1 and `ps0_alt_o`=3 with both pulses at 0.
- R4: Done with signature code 3 (dual) gives a one-cycle setup with `tcc_start_o`=1. Alternative code 0 (A) or 2 (both) enables controller 0 with `ps0_alt_o`=1 (A) and a clear pulse on `ps0_fail_clr_o`. Alternative code 1 (B) or 2 enables controller 1 with `ps1_alt_o`=2 (B) and a clear pulse on `ps1_fail_clr_o`. A disabled controller shows alt code 0 (OFF).
- R5: Done with signature code 0 (open), code 1 (invalid), single with any alternative other than both, or dual with alternative code 3 (invalid) sends the block to DISABLED for one cycle with all outputs 0. It then re-checks if enable is still high.
- R6: In dual operation the block returns to CONN_CHECK only when each alternative is either unconfigured or has its fail flag (`fail_a_i` for A, `fail_b_i` for B) at 1. A single failed, configured alternative keeps the other running.
- R7: In single operation `fail_a_i`=1 returns the block to CONN_CHECK, and `fail_b_i` has no effect on any output.
- R8: Dropping `enable_i` while pairsets are powered turns off both enables after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| enable_i | input | 1 | port enable control |
| sig_kind_i | input | 2 | signature type: 0 open, 1 invalid, 2 single, 3 dual |
| pd_alt_i | input | 2 | device alternative: 0 A, 1 B, 2 both, 3 invalid |
| chk_done_i | input | 1 | check functions finished, results valid |
| fail_a_i | input | 1 | detection-fail flag from the Alt-A controller |
| fail_b_i | input | 1 | detection-fail flag from the Alt-B controller |
| chk_req_o | output | 1 | request connection check and device-alternative check |
| tcc_start_o | output | 1 | one-cycle start of the check-to-detection timer |
| ps0_en_o | output | 1 | enable of pairset controller 0 |
| ps0_alt_o | output | 2 | controller 0 alternative: 0 off, 1 A, 3 both |
| ps0_fail_clr_o | output | 1 | clear pulse for controller 0 fail flag |
| ps1_en_o | output | 1 | enable of pairset controller 1 (Alt-B) |
| ps1_alt_o | output | 2 | controller 1 alternative: 0 off, 2 B |
| ps1_fail_clr_o | output | 1 | clear pulse for controller 1 fail flag |

## Verification
The block has no width or depth parameters, so the bench builds it as it is and walks every state and every named transition. It applies each signature and alternative combination that selects a distinct setup or a return to DISABLED. In the running states it toggles the fail flags one at a time and then together, which shows that an unconfigured alternative counts as released and that the unused flag is ignored in shared mode. It also drops enable mid-operation and holds garbage check results while done is low.

// File: rtl/qps_pkg.sv
package qps_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        SIG_OPEN    = 2'd0,
        SIG_INVALID = 2'd1,
        SIG_SINGLE  = 2'd2,
        SIG_DUAL    = 2'd3
    } sig_kind_e;

    typedef enum logic [CODE_W-1:0] {
        PDA_A    = 2'd0,
        PDA_B    = 2'd1,
        PDA_BOTH = 2'd2,
        PDA_NONE = 2'd3
    } pd_alt_e;

    typedef enum logic [CODE_W-1:0] {
        SEL_OFF  = 2'd0,
        SEL_A    = 2'd1,
        SEL_B    = 2'd2,
        SEL_BOTH = 2'd3
    } alt_sel_e;

    typedef enum logic [2:0] {
        ST_DISABLED     = 3'd0,
        ST_CONN_CHECK   = 3'd1,
        ST_SETUP_SINGLE = 3'd2,
        ST_SETUP_DUAL   = 3'd3,
        ST_RUN_SINGLE   = 3'd4,
        ST_RUN_DUAL     = 3'd5
    } sup_state_e;
endpackage

// File: rtl/qps_decide.sv
module qps_decide
    import qps_pkg::*;
(
    input  sig_kind_e sig_i,
    input  pd_alt_e   alt_i,
    output logic      single_o,
    output logic      dual_o,
    output logic      use_a_o,
    output logic      use_b_o
);
    always_comb begin
        use_a_o  = (alt_i == PDA_A) || (alt_i == PDA_BOTH);
        use_b_o  = (alt_i == PDA_B) || (alt_i == PDA_BOTH);
        single_o = (sig_i == SIG_SINGLE) && (alt_i == PDA_BOTH);
        dual_o   = (sig_i == SIG_DUAL) && (use_a_o || use_b_o);
    end
endmodule

// File: rtl/qps_result_reg.sv
module qps_result_reg
    import qps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear_i,
    input  logic      load_i,
    input  sig_kind_e sig_i,
    input  pd_alt_e   alt_i,
    output sig_kind_e sig_q,
    output pd_alt_e   alt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= SIG_INVALID;
            alt_q <= PDA_NONE;
        end else if (clear_i) begin
            sig_q <= SIG_INVALID;
            alt_q <= PDA_NONE;
        end else if (load_i) begin
            sig_q <= sig_i;
            alt_q <= alt_i;
        end
    end
endmodule

// File: rtl/qps_release.sv
module qps_release (
    input  logic single_i,
    input  logic use_a_i,
    input  logic use_b_i,
    input  logic fail_a_i,
    input  logic fail_b_i,
    output logic release_o
);
    logic done_a;
    logic done_b;

    always_comb begin
        done_a = fail_a_i || !use_a_i;
        done_b = fail_b_i || !use_b_i;
        if (single_i) begin
            release_o = fail_a_i;
        end else begin
            release_o = done_a && done_b;
        end
    end
endmodule

// File: rtl/quad_pair_supervisor.sv
module quad_pair_supervisor
    import qps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic [1:0] sig_kind_i,
    input  logic [1:0] pd_alt_i,
    input  logic       chk_done_i,
    input  logic       fail_a_i,
    input  logic       fail_b_i,
    output logic       chk_req_o,
    output logic       tcc_start_o,
    output logic       ps0_en_o,
    output logic [1:0] ps0_alt_o,
    output logic       ps0_fail_clr_o,
    output logic       ps1_en_o,
    output logic [1:0] ps1_alt_o,
    output logic       ps1_fail_clr_o
);
    sup_state_e state_q;
    sup_state_e state_d;

    logic      live_single, live_dual, live_use_a, live_use_b;
    logic      q_single, q_dual, q_use_a, q_use_b;
    logic      released;
    sig_kind_e sig_q;
    pd_alt_e   alt_q;
    logic      load_res;
    logic      clear_res;

    assign load_res  = (state_q == ST_CONN_CHECK) && chk_done_i;
    assign clear_res = (state_q == ST_DISABLED);

    qps_decide u_live_decide (
        .sig_i    (sig_kind_e'(sig_kind_i)),
        .alt_i    (pd_alt_e'(pd_alt_i)),
        .single_o (live_single),
        .dual_o   (live_dual),
        .use_a_o  (live_use_a),
        .use_b_o  (live_use_b)
    );

    qps_result_reg u_results (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_res),
        .load_i  (load_res),
        .sig_i   (sig_kind_e'(sig_kind_i)),
        .alt_i   (pd_alt_e'(pd_alt_i)),
        .sig_q   (sig_q),
        .alt_q   (alt_q)
    );

    qps_decide u_held_decide (
        .sig_i    (sig_q),
        .alt_i    (alt_q),
        .single_o (q_single),
        .dual_o   (q_dual),
        .use_a_o  (q_use_a),
        .use_b_o  (q_use_b)
    );

    qps_release u_release (
        .single_i  (state_q == ST_RUN_SINGLE),
        .use_a_i   (q_use_a),
        .use_b_i   (q_use_b),
        .fail_a_i  (fail_a_i),
        .fail_b_i  (fail_b_i),
        .release_o (released)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DISABLED;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISABLED: begin
                state_d = ST_CONN_CHECK;
            end
            ST_CONN_CHECK: begin
                if (chk_done_i) begin
                    if (live_single) begin
                        state_d = ST_SETUP_SINGLE;
                    end else if (live_dual) begin
                        state_d = ST_SETUP_DUAL;
                    end else begin
                        state_d = ST_DISABLED;
                    end
                end
            end
            ST_SETUP_SINGLE: state_d = ST_RUN_SINGLE;
            ST_SETUP_DUAL:   state_d = ST_RUN_DUAL;
            ST_RUN_SINGLE, ST_RUN_DUAL: begin
                if (released) begin
                    state_d = ST_CONN_CHECK;
                end
            end
            default: state_d = ST_DISABLED;
        endcase
        if (!enable_i) begin
            state_d = ST_DISABLED;
        end
    end

    // output decode
    always_comb begin
        chk_req_o      = 1'b0;
        tcc_start_o    = 1'b0;
        ps0_en_o       = 1'b0;
        ps0_alt_o      = SEL_OFF;
        ps0_fail_clr_o = 1'b0;
        ps1_en_o       = 1'b0;
        ps1_alt_o      = SEL_OFF;
        ps1_fail_clr_o = 1'b0;
        unique case (state_q)
            ST_DISABLED: begin
            end
            ST_CONN_CHECK: begin
                chk_req_o = 1'b1;
            end
            ST_SETUP_SINGLE, ST_RUN_SINGLE: begin
                ps0_en_o  = q_single;
                ps0_alt_o = q_single ? SEL_BOTH : SEL_OFF;
                if (state_q == ST_SETUP_SINGLE) begin
                    tcc_start_o    = 1'b1;
                    ps0_fail_clr_o = 1'b1;
                end
            end
            ST_SETUP_DUAL, ST_RUN_DUAL: begin
                ps0_en_o  = q_dual && q_use_a;
                ps0_alt_o = (q_dual && q_use_a) ? SEL_A : SEL_OFF;
                ps1_en_o  = q_dual && q_use_b;
                ps1_alt_o = (q_dual && q_use_b) ? SEL_B : SEL_OFF;
                if (state_q == ST_SETUP_DUAL) begin
                    tcc_start_o    = 1'b1;
                    ps0_fail_clr_o = q_use_a;
                    ps1_fail_clr_o = q_use_b;
                end
            end
            default: begin
            end
        endcase
    end

    // R1
    off_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!chk_req_o && !tcc_start_o && !ps0_en_o && !ps1_en_o));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req_o && !chk_done_i && enable_i) |=> chk_req_o);

    // R3
    tcc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tcc_start_o |=> !tcc_start_o);

    // R4
    enable_rise_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps0_en_o) |-> ps0_fail_clr_o);

    // R6
    dual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_DUAL && enable_i && !fail_a_i && !fail_b_i) |=> !chk_req_o);

    // R7
    shared_excludes_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps0_alt_o == SEL_BOTH) |-> (!ps1_en_o && !ps1_fail_clr_o));
endmodule

// File: tb/quad_pair_supervisor_test.sv
`timescale 1ns/100ps
module quad_pair_supervisor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic [1:0] sig_kind_i = 2'd1;
    logic [1:0] pd_alt_i = 2'd3;
    logic       chk_done_i = 1'b0;
    logic       fail_a_i = 1'b0;
    logic       fail_b_i = 1'b0;
    logic       chk_req_o, tcc_start_o, ps0_en_o, ps0_fail_clr_o, ps1_en_o, ps1_fail_clr_o;
    logic [1:0] ps0_alt_o, ps1_alt_o;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    quad_pair_supervisor uut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sig_kind_i(sig_kind_i),
        .pd_alt_i(pd_alt_i), .chk_done_i(chk_done_i), .fail_a_i(fail_a_i),
        .fail_b_i(fail_b_i), .chk_req_o(chk_req_o), .tcc_start_o(tcc_start_o),
        .ps0_en_o(ps0_en_o), .ps0_alt_o(ps0_alt_o), .ps0_fail_clr_o(ps0_fail_clr_o),
        .ps1_en_o(ps1_en_o), .ps1_alt_o(ps1_alt_o), .ps1_fail_clr_o(ps1_fail_clr_o)
    );

    function automatic logic [9:0] mk(input logic chk, input logic tcc, input logic e0,
                                      input logic [1:0] a0, input logic c0, input logic e1,
                                      input logic [1:0] a1, input logic c1);
        return {chk, tcc, e0, a0, c0, e1, a1, c1};
    endfunction

    localparam logic [9:0] E_OFF   = 10'b0;
    localparam logic [9:0] E_CHK   = 10'b10_0000_0000;
    localparam logic [9:0] E_S_SET = 10'b01_1111_0000;
    localparam logic [9:0] E_S_RUN = 10'b00_1110_0000;
    localparam logic [9:0] E_A_SET = 10'b01_1011_0000;
    localparam logic [9:0] E_A_RUN = 10'b00_1010_0000;
    localparam logic [9:0] E_B_SET = 10'b01_0000_1101;
    localparam logic [9:0] E_B_RUN = 10'b00_0000_1100;
    localparam logic [9:0] E_D_SET = 10'b01_1011_1101;
    localparam logic [9:0] E_D_RUN = 10'b00_1010_1100;

    task automatic apply(input logic en, input logic [1:0] sig, input logic [1:0] alt,
                         input logic done, input logic fa, input logic fb,
                         input logic [9:0] expv, input string tag);
        @(negedge clk);
        enable_i   = en;
        sig_kind_i = sig;
        pd_alt_i   = alt;
        chk_done_i = done;
        fail_a_i   = fa;
        fail_b_i   = fb;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
    endtask

    // monitor: compares one expected item after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                logic [9:0] e;
                logic [9:0] got;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = mk(chk_req_o, tcc_start_o, ps0_en_o, ps0_alt_o, ps0_fail_clr_o,
                         ps1_en_o, ps1_alt_o, ps1_fail_clr_o);
                vectors++;
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s: got %b expected %b", t, got, e);
                end
            end
        end
    end

    initial begin
        // R1 reset state
        apply(1, 2, 2, 1, 0, 0, E_OFF, "R1 reset");
        apply(1, 2, 2, 1, 0, 0, E_OFF, "R1 reset hold");
        @(negedge clk) rst_n = 1'b1;
        apply(0, 2, 2, 1, 0, 0, E_OFF, "R1 enable low");
        // R2 check request held until done; garbage results ignored
        apply(1, 3, 2, 0, 0, 0, E_CHK, "R2 enter check");
        apply(1, 3, 2, 0, 0, 0, E_CHK, "R2 hold no done");
        apply(1, 0, 3, 0, 0, 0, E_CHK, "R2 results ignored");
        // R3 single signature, both alternatives
        apply(1, 2, 2, 1, 0, 0, E_S_SET, "R3 single setup");
        apply(1, 0, 3, 0, 0, 0, E_S_RUN, "R3 single run");
        apply(1, 0, 3, 0, 0, 1, E_S_RUN, "R7 fail_b ignored");
        apply(1, 0, 3, 0, 0, 1, E_S_RUN, "R7 fail_b ignored hold");
        apply(1, 0, 3, 0, 1, 0, E_CHK, "R7 fail_a release");
        // R4 dual, A only
        apply(1, 3, 0, 1, 0, 0, E_A_SET, "R4 dual A setup");
        apply(1, 0, 3, 0, 0, 0, E_A_RUN, "R4 dual A run");
        apply(1, 0, 3, 0, 0, 1, E_A_RUN, "R6 unused B flag alone");
        apply(1, 0, 3, 0, 1, 0, E_CHK, "R6 A fail with B unconfigured");
        // R4 dual, B only
        apply(1, 3, 1, 1, 0, 0, E_B_SET, "R4 dual B setup");
        apply(1, 0, 3, 0, 0, 0, E_B_RUN, "R4 dual B run");
        apply(1, 0, 3, 0, 1, 0, E_B_RUN, "R6 A flag with B running");
        apply(1, 0, 3, 0, 1, 1, E_CHK, "R6 B fail release");
        // R4 dual, both
        apply(1, 3, 2, 1, 0, 0, E_D_SET, "R4 dual both setup");
        apply(1, 0, 3, 0, 0, 0, E_D_RUN, "R4 dual both run");
        apply(1, 0, 3, 0, 1, 0, E_D_RUN, "R6 only A failed");
        apply(1, 0, 3, 0, 0, 1, E_D_RUN, "R6 only B failed");
        apply(1, 0, 3, 0, 1, 1, E_CHK, "R6 both failed");
        // R5 rejected results
        apply(1, 0, 2, 1, 0, 0, E_OFF, "R5 open");
        apply(1, 0, 2, 0, 0, 0, E_CHK, "R5 recheck after open");
        apply(1, 1, 2, 1, 0, 0, E_OFF, "R5 invalid");
        apply(1, 1, 2, 0, 0, 0, E_CHK, "R5 recheck after invalid");
        apply(1, 2, 0, 1, 0, 0, E_OFF, "R5 single without both");
        apply(1, 2, 0, 0, 0, 0, E_CHK, "R5 recheck after single A");
        apply(1, 3, 3, 1, 0, 0, E_OFF, "R5 dual invalid alt");
        apply(1, 3, 3, 0, 0, 0, E_CHK, "R5 recheck after dual invalid");
        // R8 disable while powered
        apply(1, 2, 2, 1, 0, 0, E_S_SET, "R3 single setup again");
        apply(1, 0, 3, 0, 0, 0, E_S_RUN, "R3 single run again");
        apply(0, 0, 3, 0, 0, 0, E_OFF, "R8 disable while powered");
        apply(0, 2, 2, 1, 0, 0, E_OFF, "R1 stays disabled");
        apply(1, 2, 2, 0, 0, 0, E_CHK, "R2 re-enable");
        apply(0, 3, 2, 1, 0, 0, E_OFF, "R1 disable beats done");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule